// File: doc/BRIEF.md
# Smart-Panel Command Bridge

This block lets a register-mapped host drive up to two external smart display panels over a shared 16-bit parallel bus. Each panel has its own chip select. A write to one of the bus registers becomes one or more bus cycles, and each cycle carries a command/data flag. Command and parameter words go out once to every enabled select. A 32-bit pixel data word is split into two 16-bit cycles. A write to a read or status trigger register fetches one 16-bit word back from a single panel. That word is then available at two register offsets.

The block also keeps a pixel counter. A control write can launch a counted transfer, which marks the block busy. Each pixel data write, panel read or panel status access takes one off the count. When the count reaches zero, busy drops and a one-cycle frame-done pulse is sent to the display controller so it can set its interrupt status. A register access that needs bus cycles is stalled through the ready signal until its last cycle has gone out. Cycles are issued back to back, one per clock, with chip select 0 first.

Register offsets (byte address): 0x00 system configuration, 0x04 system status, 0x08 control, 0x0C pixel count, 0x10 line number, 0x14 command, 0x18 parameter, 0x1C pixel data, 0x20 panel read, 0x24 panel status, 0x28 configuration A, 0x2C configuration B, 0x30 vertical sync width, 0x34 horizontal sync width. Any other offset reads 0.

Top module: `panel_cmd_bridge`

## Requirements
- R1: After reset, control reads 0x2, both configuration registers read 0x00310000, system status reads 0x1, and pixel count, line number, sync widths and system configuration read 0.
- R2: Stored fields are masked on write: control keeps bits 3:0 (bit 0 enable, bit 1 bypass, bit 2 select 0 on, bit 3 select 1 on), configuration keeps the value AND 0x003F1FFF, line number keeps 11 bits, sync widths keep 16 bits, and system configuration keeps the value AND 0x19. Writes to system status have no effect.
- R3: A command write drives wdata[15:0] with the flag at 0 (command) for one cycle on each enabled select, select 0 first, in consecutive clocks. A parameter write does the same with the flag at 1.
- R4: A pixel data write drives, for each enabled select in turn (select 0 first), a cycle carrying wdata[15:0] and then a cycle carrying wdata[31:16], all with the flag at 1.
- R5: A write to the panel read register (flag 1) or the panel status register (flag 0) performs one read cycle, on select 0 if it is enabled and otherwise on select 1. The 16 bits captured in that cycle are returned by reads of both registers.
- R6: An access that produces N bus cycles raises ready only after the last cycle, N+1 clocks after the request appears. An access that produces no bus cycle (no select enabled, or a non-bus register) is ready at once.
- R7: A control write with bit 4 set starts a transfer only if the written enable bit is 1, the written bypass bit is 0, the mode input is high, the block is not busy, and configuration A bits 3:2 AND configuration B bits 3:2 equal 0. Busy shows in system status bit 8; bit 0 always reads 1.
- R8: Each pixel data, panel read and panel status access lowers the pixel count by one. When the count reaches zero during a transfer, busy clears and frame_done_o is high for exactly one clock.
- R9: A transfer started while the pixel count is 0 completes at once: frame_done_o pulses and busy stays 0.
- R10: A decrement with the pixel count already at 0 leaves it at 0.
- R11: Writing system configuration with bit 1 set returns every register and busy to its reset value, then stores the written value AND 0x19 as the system configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write request, held until ready |
| reg_rd_i | input | 1 | Register read request, held until ready |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid while ready is high |
| reg_ready_o | output | 1 | Access completes at the clock edge where this is high |
| frame_mode_i | input | 1 | Display controller is in remote-panel mode |
| pnl_data_o | output | 16 | Panel bus write data |
| pnl_dc_o | output | 1 | 0 command or status, 1 data or parameter |
| pnl_wr_o | output | 1 | Write cycle strobe |
| pnl_rd_o | output | 1 | Read cycle strobe |
| pnl_cs_o | output | 2 | Chip selects, active high, one per cycle |
| pnl_rdata_i | input | 16 | Panel read data, sampled during a read cycle |
| frame_done_o | output | 1 | One-clock pulse when a transfer completes |

## Verification
The bench logs every bus cycle and checks cycle order, select, flag and half-word. A design that sent the high half first, or put chip 1 before chip 0, would show up in the logged sequence. The stall length is measured per access, so a design that raised ready before the last cycle, or inserted idle clocks between cycles, would fail the count. Each start-blocking condition is tried on its own; a design that ignored any one of them would show busy where none is expected. The bench also covers a start with a zero count, a decrement at zero that must not wrap, and a soft reset that must leave only the masked system configuration behind.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

    localparam int AW       = 8;
    localparam int NUM_CS   = 2;
    localparam int SLOT_W   = 2;

    localparam logic [AW-1:0] A_SYSCFG = 8'h00;
    localparam logic [AW-1:0] A_SYSSTA = 8'h04;
    localparam logic [AW-1:0] A_CTRL   = 8'h08;
    localparam logic [AW-1:0] A_PIXCNT = 8'h0C;
    localparam logic [AW-1:0] A_LINE   = 8'h10;
    localparam logic [AW-1:0] A_CMD    = 8'h14;
    localparam logic [AW-1:0] A_PARAM  = 8'h18;
    localparam logic [AW-1:0] A_DATA   = 8'h1C;
    localparam logic [AW-1:0] A_RDDAT  = 8'h20;
    localparam logic [AW-1:0] A_RDSTA  = 8'h24;
    localparam logic [AW-1:0] A_CFGA   = 8'h28;
    localparam logic [AW-1:0] A_CFGB   = 8'h2C;
    localparam logic [AW-1:0] A_VSW    = 8'h30;
    localparam logic [AW-1:0] A_HSW    = 8'h34;

    localparam logic [31:0] CFG_RST  = 32'h0031_0000;
    localparam logic [31:0] CFG_MASK = 32'h003F_1FFF;
    localparam logic [4:0]  IDLE_MASK = 5'h19;
    localparam logic [3:0]  CTRL_RST = 4'h2;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_CMD,
        OP_PARAM,
        OP_DATA,
        OP_READ,
        OP_STAT
    } bus_op_e;

    // slot = {select index, half}; slots are issued in ascending order
    function automatic logic slot_ok(bus_op_e op, logic [NUM_CS-1:0] cs_en,
                                     logic [SLOT_W-1:0] slot);
        logic ok;
        ok = 1'b0;
        case (op)
            OP_CMD, OP_PARAM: ok = !slot[0] && cs_en[slot[1]];
            OP_DATA:          ok = cs_en[slot[1]];
            OP_READ, OP_STAT: begin
                if (slot == 2'd0)      ok = cs_en[0];
                else if (slot == 2'd2) ok = !cs_en[0] && cs_en[1];
                else                   ok = 1'b0;
            end
            default:          ok = 1'b0;
        endcase
        return ok;
    endfunction

    function automatic logic op_is_read(bus_op_e op);
        return (op == OP_READ) || (op == OP_STAT);
    endfunction

    function automatic logic op_counts(bus_op_e op);
        return (op == OP_DATA) || (op == OP_READ) || (op == OP_STAT);
    endfunction

endpackage

// File: rtl/pcb_bus_seq.sv
module pcb_bus_seq
    import pcb_pkg::*;
#(
    parameter int BUS_W  = 16,
    parameter int WORD_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  bus_op_e             op_i,
    input  logic [NUM_CS-1:0]   cs_en_i,
    input  logic [WORD_W-1:0]   word_i,
    output logic                has_work_o,
    output logic                idle_o,
    output logic                fin_o,
    output logic                wr_stb_o,
    output logic                rd_stb_o,
    output logic                dc_o,
    output logic [NUM_CS-1:0]   cs_o,
    output logic [BUS_W-1:0]    data_o
);

    typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} seq_st_e;

    typedef struct packed {
        seq_st_e             st;
        bus_op_e             op;
        logic [NUM_CS-1:0]   cs_en;
        logic [WORD_W-1:0]   word;
        logic [SLOT_W-1:0]   slot;
    } seq_t;

    localparam int NSLOT = 1 << SLOT_W;

    seq_t q, d;
    logic [SLOT_W-1:0] first_slot, next_slot;
    logic              has_next;

    always_comb begin
        has_work_o = 1'b0;
        first_slot = '0;
        for (int s = NSLOT - 1; s >= 0; s--) begin
            if (slot_ok(op_i, cs_en_i, SLOT_W'(s))) begin
                has_work_o = 1'b1;
                first_slot = SLOT_W'(s);
            end
        end
        has_next  = 1'b0;
        next_slot = '0;
        for (int s = NSLOT - 1; s >= 0; s--) begin
            if (s > int'(q.slot) && slot_ok(q.op, q.cs_en, SLOT_W'(s))) begin
                has_next  = 1'b1;
                next_slot = SLOT_W'(s);
            end
        end
    end

    always_comb begin
        d = q;
        case (q.st)
            S_IDLE: begin
                if (start_i && has_work_o) begin
                    d.st    = S_RUN;
                    d.op    = op_i;
                    d.cs_en = cs_en_i;
                    d.word  = word_i;
                    d.slot  = first_slot;
                end
            end
            S_RUN: begin
                if (has_next) d.slot = next_slot;
                else          d.st   = S_FIN;
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: S_IDLE, op: OP_NONE, cs_en: '0, word: '0, slot: '0};
        end else begin
            q <= d;
        end
    end

    assign idle_o   = (q.st == S_IDLE);
    assign fin_o    = (q.st == S_FIN);
    assign wr_stb_o = (q.st == S_RUN) && !op_is_read(q.op);
    assign rd_stb_o = (q.st == S_RUN) && op_is_read(q.op);
    assign dc_o     = (q.st == S_RUN) && (q.op != OP_CMD) && (q.op != OP_STAT);

    generate
        for (genvar c = 0; c < NUM_CS; c++) begin : g_cs
            assign cs_o[c] = (q.st == S_RUN) && (int'(q.slot[1]) == c);
        end
    endgenerate

    assign data_o = (q.st != S_RUN || op_is_read(q.op)) ? '0 :
                    (q.slot[0] ? q.word[2*BUS_W-1:BUS_W] : q.word[BUS_W-1:0]);

endmodule

// File: rtl/pcb_pix_track.sv
module pcb_pix_track #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             dec_i,
    input  logic             start_i,
    output logic [CNT_W-1:0] count_o,
    output logic             busy_o,
    output logic             done_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             busy;
        logic             done;
    } pix_t;

    pix_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (soft_rst_i) begin
            d.cnt  = '0;
            d.busy = 1'b0;
        end else if (load_i) begin
            d.cnt = load_val_i;
        end else if (dec_i) begin
            if (q.cnt != '0) begin
                d.cnt = q.cnt - 1'b1;
                if (q.cnt == CNT_W'(1) && q.busy) begin
                    d.busy = 1'b0;
                    d.done = 1'b1;
                end
            end
        end else if (start_i) begin
            if (q.cnt == '0) d.done = 1'b1;
            else             d.busy = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{cnt: '0, busy: 1'b0, done: 1'b0};
        else        q <= d;
    end

    assign count_o = q.cnt;
    assign busy_o  = q.busy;
    assign done_o  = q.done;

endmodule

// File: rtl/panel_cmd_bridge.sv
module panel_cmd_bridge
    import pcb_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int LINE_W = 11,
    parameter int SYNC_W = 16,
    parameter int BUS_W  = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reg_wr_i,
    input  logic         reg_rd_i,
    input  logic [7:0]   reg_addr_i,
    input  logic [31:0]  reg_wdata_i,
    output logic [31:0]  reg_rdata_o,
    output logic         reg_ready_o,
    input  logic         frame_mode_i,
    output logic [15:0]  pnl_data_o,
    output logic         pnl_dc_o,
    output logic         pnl_wr_o,
    output logic         pnl_rd_o,
    output logic [1:0]   pnl_cs_o,
    input  logic [15:0]  pnl_rdata_i,
    output logic         frame_done_o
);

    localparam int WORD_W = 2 * BUS_W;

    typedef struct packed {
        logic [4:0]        idle;
        logic [3:0]        ctrl;
        logic [LINE_W-1:0] line;
        logic [31:0]       cfg_a;
        logic [31:0]       cfg_b;
        logic [SYNC_W-1:0] vsw;
        logic [SYNC_W-1:0] hsw;
        logic [BUS_W-1:0]  rxbuf;
    } regs_t;

    regs_t   q, d;
    bus_op_e op;
    logic    seq_has, seq_idle, seq_fin, seq_wr, seq_rd, seq_dc;
    logic    seq_start, accept, wr_acc, soft_rst, pix_load, pix_dec, xfer_go;
    logic    pix_busy, pix_done;
    logic [NUM_CS-1:0] seq_cs;
    logic [BUS_W-1:0]  seq_data;
    logic [CNT_W-1:0]  pix_count;

    always_comb begin
        op = OP_NONE;
        if (reg_wr_i) begin
            case (reg_addr_i)
                A_CMD:   op = OP_CMD;
                A_PARAM: op = OP_PARAM;
                A_DATA:  op = OP_DATA;
                A_RDDAT: op = OP_READ;
                A_RDSTA: op = OP_STAT;
                default: op = OP_NONE;
            endcase
        end
    end

    pcb_bus_seq #(.BUS_W(BUS_W), .WORD_W(WORD_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (seq_start),
        .op_i       (op),
        .cs_en_i    (q.ctrl[3:2]),
        .word_i     (reg_wdata_i[WORD_W-1:0]),
        .has_work_o (seq_has),
        .idle_o     (seq_idle),
        .fin_o      (seq_fin),
        .wr_stb_o   (seq_wr),
        .rd_stb_o   (seq_rd),
        .dc_o       (seq_dc),
        .cs_o       (seq_cs),
        .data_o     (seq_data)
    );

    assign reg_ready_o = (seq_idle && !seq_has) || seq_fin;
    assign accept      = (reg_wr_i || reg_rd_i) && reg_ready_o;
    assign wr_acc      = accept && reg_wr_i;
    assign seq_start   = reg_wr_i && seq_idle && seq_has;
    assign soft_rst    = wr_acc && reg_addr_i == A_SYSCFG && reg_wdata_i[1];
    assign pix_load    = wr_acc && reg_addr_i == A_PIXCNT;
    assign pix_dec     = wr_acc && op_counts(op);
    assign xfer_go     = wr_acc && reg_addr_i == A_CTRL && reg_wdata_i[4]
                         && reg_wdata_i[0] && !reg_wdata_i[1] && frame_mode_i
                         && !pix_busy && ((q.cfg_a[3:2] & q.cfg_b[3:2]) == 2'b00);

    pcb_pix_track #(.CNT_W(CNT_W)) u_pix (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst_i (soft_rst),
        .load_i     (pix_load),
        .load_val_i (reg_wdata_i[CNT_W-1:0]),
        .dec_i      (pix_dec),
        .start_i    (xfer_go),
        .count_o    (pix_count),
        .busy_o     (pix_busy),
        .done_o     (pix_done)
    );

    function automatic regs_t regs_rst();
        regs_t r;
        r.idle  = '0;
        r.ctrl  = CTRL_RST;
        r.line  = '0;
        r.cfg_a = CFG_RST;
        r.cfg_b = CFG_RST;
        r.vsw   = '0;
        r.hsw   = '0;
        r.rxbuf = '0;
        return r;
    endfunction

    always_comb begin
        d = q;
        if (seq_rd) d.rxbuf = pnl_rdata_i;
        if (wr_acc) begin
            case (reg_addr_i)
                A_SYSCFG: begin
                    if (reg_wdata_i[1]) begin
                        d       = regs_rst();
                        d.rxbuf = q.rxbuf;
                    end
                    d.idle = reg_wdata_i[4:0] & IDLE_MASK;
                end
                A_CTRL:  d.ctrl  = reg_wdata_i[3:0];
                A_LINE:  d.line  = reg_wdata_i[LINE_W-1:0];
                A_CFGA:  d.cfg_a = reg_wdata_i & CFG_MASK;
                A_CFGB:  d.cfg_b = reg_wdata_i & CFG_MASK;
                A_VSW:   d.vsw   = reg_wdata_i[SYNC_W-1:0];
                A_HSW:   d.hsw   = reg_wdata_i[SYNC_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= regs_rst();
        else        q <= d;
    end

    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            A_SYSCFG: reg_rdata_o = 32'(q.idle);
            A_SYSSTA: reg_rdata_o = {23'd0, pix_busy, 7'd0, 1'b1};
            A_CTRL:   reg_rdata_o = 32'(q.ctrl);
            A_PIXCNT: reg_rdata_o = 32'(pix_count);
            A_LINE:   reg_rdata_o = 32'(q.line);
            A_RDDAT,
            A_RDSTA:  reg_rdata_o = 32'(q.rxbuf);
            A_CFGA:   reg_rdata_o = q.cfg_a;
            A_CFGB:   reg_rdata_o = q.cfg_b;
            A_VSW:    reg_rdata_o = 32'(q.vsw);
            A_HSW:    reg_rdata_o = 32'(q.hsw);
            default:  reg_rdata_o = '0;
        endcase
    end

    assign pnl_data_o   = seq_data;
    assign pnl_dc_o     = seq_dc;
    assign pnl_wr_o     = seq_wr;
    assign pnl_rd_o     = seq_rd;
    assign pnl_cs_o     = seq_cs;
    assign frame_done_o = pix_done;

endmodule

// File: rtl/pcb_checker.sv
module pcb_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pnl_wr_o,
    input logic             pnl_rd_o,
    input logic [1:0]       pnl_cs_o,
    input logic             reg_ready_o,
    input logic             frame_done_o,
    input logic             busy,
    input logic [CNT_W-1:0] count,
    input logic             load,
    input logic             soft_rst
);

    // R3
    cs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pnl_wr_o || pnl_rd_o) |-> $countones(pnl_cs_o) == 1);

    // R3
    cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pnl_wr_o || pnl_rd_o) |-> $onehot0(pnl_cs_o) && pnl_cs_o == 2'b00);

    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pnl_wr_o && pnl_rd_o));

    // R6
    stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pnl_wr_o || pnl_rd_o) |-> !reg_ready_o);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_o |-> !busy);

    // R10
    zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && !load && !soft_rst) |=> count == '0);

endmodule

bind panel_cmd_bridge pcb_checker #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pnl_wr_o     (pnl_wr_o),
    .pnl_rd_o     (pnl_rd_o),
    .pnl_cs_o     (pnl_cs_o),
    .reg_ready_o  (reg_ready_o),
    .frame_done_o (frame_done_o),
    .busy         (pix_busy),
    .count        (pix_count),
    .load         (pix_load),
    .soft_rst     (soft_rst)
);

// File: tb/sim_panel_cmd_bridge.sv
module sim_panel_cmd_bridge;

    localparam logic [7:0] A_SYSCFG = 8'h00, A_SYSSTA = 8'h04, A_CTRL = 8'h08,
        A_PIXCNT = 8'h0C, A_LINE = 8'h10, A_CMD = 8'h14, A_PARAM = 8'h18,
        A_DATA = 8'h1C, A_RDDAT = 8'h20, A_RDSTA = 8'h24, A_CFGA = 8'h28,
        A_CFGB = 8'h2C, A_VSW = 8'h30, A_HSW = 8'h34;

    typedef struct packed {
        logic [7:0]  addr;
        logic [31:0] wdata;
        logic [31:0] expv;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VEC [NVEC] = '{
        '{A_CTRL,   32'hFFFF_FFEF, 32'h0000_000F},
        '{A_CFGA,   32'hFFFF_FFFF, 32'h003F_1FFF},
        '{A_CFGB,   32'h1234_5678, 32'h0034_1678},
        '{A_LINE,   32'h0000_FFFF, 32'h0000_07FF},
        '{A_VSW,    32'hABCD_EF01, 32'h0000_EF01},
        '{A_HSW,    32'h0001_2345, 32'h0000_2345},
        '{A_PIXCNT, 32'h0000_0005, 32'h0000_0005},
        '{A_SYSSTA, 32'h0000_FFFF, 32'h0000_0001},
        '{A_SYSCFG, 32'h0000_00FD, 32'h0000_0019}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_ready;
    logic        frame_mode = 1'b0;
    logic [15:0] pnl_data;
    logic        pnl_dc, pnl_wr, pnl_rd;
    logic [1:0]  pnl_cs;
    logic [15:0] pnl_rdata = '0;
    logic        frame_done;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    panel_cmd_bridge u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd),
        .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
        .reg_ready_o(reg_ready), .frame_mode_i(frame_mode), .pnl_data_o(pnl_data),
        .pnl_dc_o(pnl_dc), .pnl_wr_o(pnl_wr), .pnl_rd_o(pnl_rd), .pnl_cs_o(pnl_cs),
        .pnl_rdata_i(pnl_rdata), .frame_done_o(frame_done)
    );

    // bus cycle log entry: {rd, cs[1:0], dc, data[15:0]}
    logic [19:0] log_ent [64];
    int          log_cyc [64];
    int          log_n = 0;
    int          cyc = 0;
    int          fd_cnt = 0;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (pnl_wr || pnl_rd) begin
            log_ent[log_n % 64] <= {pnl_rd, pnl_cs, pnl_dc, (pnl_rd ? pnl_rdata : pnl_data)};
            log_cyc[log_n % 64] <= cyc;
            log_n <= log_n + 1;
        end
        if (frame_done) fd_cnt <= fd_cnt + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic access(input logic wr, input logic [7:0] addr, input logic [31:0] data,
                          output logic [31:0] rdata, output int waits);
        @(negedge clk);
        reg_wr = wr; reg_rd = !wr; reg_addr = addr; reg_wdata = data;
        #1;
        waits = 0;
        while (!reg_ready) begin
            @(negedge clk);
            waits++;
        end
        rdata = reg_rdata;
        @(negedge clk);
        reg_wr = 1'b0; reg_rd = 1'b0;
        #1;
    endtask

    task automatic wr(input logic [7:0] addr, input logic [31:0] data);
        logic [31:0] rd_v; int w;
        access(1'b1, addr, data, rd_v, w);
    endtask

    task automatic rd_chk(input string req, input logic [7:0] addr, input logic [31:0] expv);
        logic [31:0] rd_v; int w;
        access(1'b0, addr, 32'd0, rd_v, w);
        chk(req, rd_v, expv);
    endtask

    task automatic log_chk(input string req, input int idx, input logic [19:0] expv);
        chk(req, 32'(log_ent[idx % 64]), 32'(expv));
    endtask

    initial begin
        logic timed_out;
        timed_out = 1'b0;
        fork
            begin
                logic [31:0] rv; int w; int base; int fd0;
                repeat (3) @(negedge clk);
                rst_n = 1'b1;

                // R1 reset state
                rd_chk("R1 ctrl", A_CTRL, 32'h2);
                rd_chk("R1 cfga", A_CFGA, 32'h0031_0000);
                rd_chk("R1 cfgb", A_CFGB, 32'h0031_0000);
                rd_chk("R1 sysstat", A_SYSSTA, 32'h1);
                rd_chk("R1 pixcnt", A_PIXCNT, 32'h0);
                rd_chk("R1 line", A_LINE, 32'h0);
                rd_chk("R1 syscfg", A_SYSCFG, 32'h0);

                // R2 masking table
                for (int i = 0; i < NVEC; i++) begin
                    wr(VEC[i].addr, VEC[i].wdata);
                    rd_chk("R2 mask", VEC[i].addr, VEC[i].expv);
                end
                wr(A_CFGA, 32'h0); wr(A_CFGB, 32'h0);

                // R3 command to both selects, R6 stall length
                wr(A_CTRL, 32'hC);
                base = log_n;
                access(1'b1, A_CMD, 32'hDEAD_1234, rv, w);
                chk("R3 cmd count", 32'(log_n - base), 32'd2);
                log_chk("R3 cmd cs0", base, {1'b0, 2'b01, 1'b0, 16'h1234});
                log_chk("R3 cmd cs1", base + 1, {1'b0, 2'b10, 1'b0, 16'h1234});
                chk("R3 back-to-back", 32'(log_cyc[(base + 1) % 64] - log_cyc[base % 64]), 32'd1);
                chk("R6 cmd stall", 32'(w), 32'd3);

                // R3 parameter to select 0 only
                wr(A_CTRL, 32'h4);
                base = log_n;
                access(1'b1, A_PARAM, 32'h0000_BEEF, rv, w);
                chk("R3 param count", 32'(log_n - base), 32'd1);
                log_chk("R3 param", base, {1'b0, 2'b01, 1'b1, 16'hBEEF});
                chk("R6 param stall", 32'(w), 32'd2);

                // R4 data split, R8 decrement
                wr(A_CTRL, 32'hC); wr(A_PIXCNT, 32'd3);
                base = log_n;
                access(1'b1, A_DATA, 32'hCAFE_0123, rv, w);
                chk("R4 data count", 32'(log_n - base), 32'd4);
                log_chk("R4 cs0 lo", base,     {1'b0, 2'b01, 1'b1, 16'h0123});
                log_chk("R4 cs0 hi", base + 1, {1'b0, 2'b01, 1'b1, 16'hCAFE});
                log_chk("R4 cs1 lo", base + 2, {1'b0, 2'b10, 1'b1, 16'h0123});
                log_chk("R4 cs1 hi", base + 3, {1'b0, 2'b10, 1'b1, 16'hCAFE});
                chk("R6 data stall", 32'(w), 32'd5);
                rd_chk("R8 dec data", A_PIXCNT, 32'd2);

                // R5 read from select 0
                pnl_rdata = 16'h5A5A;
                base = log_n;
                wr(A_RDDAT, 32'h0);
                chk("R5 read count", 32'(log_n - base), 32'd1);
                log_chk("R5 read cs0", base, {1'b1, 2'b01, 1'b1, 16'h5A5A});
                rd_chk("R5 read reg", A_RDDAT, 32'h5A5A);
                rd_chk("R5 stat reg", A_RDSTA, 32'h5A5A);
                rd_chk("R8 dec read", A_PIXCNT, 32'd1);

                // R5 status from select 1
                wr(A_CTRL, 32'h8);
                pnl_rdata = 16'h3C3C;
                base = log_n; fd0 = fd_cnt;
                wr(A_RDSTA, 32'h0);
                log_chk("R5 stat cs1", base, {1'b1, 2'b10, 1'b0, 16'h3C3C});
                rd_chk("R5 read reg shared", A_RDDAT, 32'h3C3C);
                rd_chk("R8 dec stat", A_PIXCNT, 32'd0);
                chk("R8 no done when idle", 32'(fd_cnt - fd0), 32'd0);

                // R6 no select enabled
                wr(A_CTRL, 32'h0);
                base = log_n;
                access(1'b1, A_CMD, 32'h1111, rv, w);
                chk("R6 no-cs cycles", 32'(log_n - base), 32'd0);
                chk("R6 no-cs stall", 32'(w), 32'd0);

                // R10 decrement at zero holds
                wr(A_DATA, 32'h1);
                rd_chk("R10 zero hold", A_PIXCNT, 32'd0);

                // R7/R8 counted transfer
                frame_mode = 1'b1;
                wr(A_PIXCNT, 32'd2);
                wr(A_CTRL, 32'h1D);
                rd_chk("R7 busy set", A_SYSSTA, 32'h101);
                fd0 = fd_cnt;
                wr(A_DATA, 32'h0);
                rd_chk("R8 still busy", A_SYSSTA, 32'h101);
                wr(A_DATA, 32'h0);
                chk("R8 done pulse", 32'(fd_cnt - fd0), 32'd1);
                @(negedge clk); #1;
                chk("R8 pulse one clock", 32'(frame_done), 32'd0);
                rd_chk("R8 busy clear", A_SYSSTA, 32'h1);

                // R7 blocking conditions
                wr(A_PIXCNT, 32'd3);
                wr(A_CTRL, 32'h13);
                rd_chk("R7 bypass blocks", A_SYSSTA, 32'h1);
                frame_mode = 1'b0;
                wr(A_CTRL, 32'h11);
                rd_chk("R7 mode blocks", A_SYSSTA, 32'h1);
                frame_mode = 1'b1;
                wr(A_CTRL, 32'h10);
                rd_chk("R7 enable blocks", A_SYSSTA, 32'h1);
                wr(A_CFGA, 32'h4); wr(A_CFGB, 32'h4);
                wr(A_CTRL, 32'h11);
                rd_chk("R7 cfg blocks", A_SYSSTA, 32'h1);
                wr(A_CFGB, 32'h8);
                wr(A_CTRL, 32'h11);
                rd_chk("R7 cfg disjoint starts", A_SYSSTA, 32'h101);
                fd0 = fd_cnt;
                wr(A_CTRL, 32'h11);
                chk("R7 restart while busy", 32'(fd_cnt - fd0), 32'd0);
                rd_chk("R7 count kept", A_PIXCNT, 32'd3);

                // R11 soft reset
                wr(A_SYSCFG, 32'h1B);
                rd_chk("R11 syscfg", A_SYSCFG, 32'h19);
                rd_chk("R11 ctrl", A_CTRL, 32'h2);
                rd_chk("R11 cfga", A_CFGA, 32'h0031_0000);
                rd_chk("R11 sysstat", A_SYSSTA, 32'h1);
                rd_chk("R11 pixcnt", A_PIXCNT, 32'h0);

                // R9 start with zero count
                wr(A_CFGA, 32'h0);
                fd0 = fd_cnt;
                wr(A_CTRL, 32'h11);
                chk("R9 immediate done", 32'(fd_cnt - fd0), 32'd1);
                rd_chk("R9 no busy", A_SYSSTA, 32'h1);
            end
            begin
                #(20 * 150000);
                timed_out = 1'b1;
            end
        join_any
        if (timed_out) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule